// File: doc/BRIEF.md
# Carry-Aware Integer ALU

This block is the combinational datapath of a small microcontroller-style core. It takes a first register operand and an operation code. The second operand is either a second register value or a zero-extended short immediate, chosen by an immediate-select flag. It also takes the carry flag currently held by the core. In the same cycle it returns a result word, the value the carry flag should take next, and a flag that tells the core whether the carry flag should be written at all.

Subtractions keep the carry in its inverted-borrow sense. A set carry means no borrow occurred, and the chained forms subtract the complement of the incoming carry. Reverse forms swap the operands, so the second operand is the minuend. A leading-bit search walks the first operand from its most significant bit downward. It looks for a bit equal to bit 0 of the second operand and reports the data width when none is found. The register file, the carry register itself and instruction decode belong to the surrounding core.

Top module: `carry_alu`

## Requirements
- R1: When `imm_sel_i` is 1 the second operand is `imm_i` zero-extended to the data width and `rs2_i` has no effect. When it is 0 the second operand is `rs2_i`.
- R2: Opcode 0 (add) gives `rs1 + op2`. Opcode 1 (add with carry) gives `rs1 + op2 + carry_i`. For both, `carry_o` is the bit just above the data width of the full-precision sum.
- R3: Opcode 2 (subtract) gives `rs1 - op2`. Opcode 3 (chained subtract) gives `rs1 - op2 - (1 - carry_i)`. For both, `carry_o` is 1 when no borrow occurred and 0 when one did.
- R4: Opcode 4 (reverse subtract) gives `op2 - rs1`. Opcode 5 (reverse chained subtract) gives `op2 - rs1 - (1 - carry_i)`. For both, the carry is an inverted borrow, as in R3.
- R5: Opcode 6 shifts `rs1` left and opcode 7 shifts it right, logically, by the low 5 bits of `op2`. Higher bits of `op2` are ignored.
- R6: Opcodes 8, 9 and 10 give the bitwise AND, OR and XOR of `rs1` and `op2`. Opcode 11 gives the bitwise complement of `rs1`, and `op2` has no effect on it.
- R7: Opcode 12 gives the smaller and opcode 13 the larger of `rs1` and `op2`, both compared as unsigned values.
- R8: Opcode 14 clears and opcode 15 sets, in `rs1`, the bit whose index is the low 5 bits of `op2`.
- R9: Opcode 16 gives the highest bit index of `rs1` whose value equals `op2[0]`, or 32 if no bit of `rs1` matches.
- R10: `carry_we_o` is 1 exactly for opcodes 0 to 5. For every other opcode, `carry_o` equals `carry_i`.
- R11: Opcodes 17 to 31 are undefined. They give a zero result, `carry_o` equal to `carry_i` and `carry_we_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| imm_sel_i | input | 1 | 1 selects the immediate as second operand |
| rs1_i | input | 32 | First register operand |
| rs2_i | input | 32 | Second register operand |
| imm_i | input | 8 | Short immediate, zero-extended |
| carry_i | input | 1 | Carry flag currently held by the core |
| result_o | output | 32 | Operation result |
| carry_o | output | 1 | Next carry value |
| carry_we_o | output | 1 | Carry write enable |

## Verification
The block holds no state. A wrong internal decision therefore shows at the ports in the same evaluation, with no delay. Examples are a carry-in routed to the wrong term, an operand swap left out of a reverse form, or a scan that stops at the wrong end. The most telling cases sit on boundaries: exact-equal subtraction, where the carry must read 1; full-word overflow; shift amounts with bits above the low five set; and search inputs with no matching bit. A mistake in the carry polarity or the write enable would only corrupt a later chained operation in the core. For that reason the carry output and the write enable are checked on every vector and every opcode, not only on the arithmetic ones.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SUC  = 5'd3,
      OP_RSB  = 5'd4,
      OP_RSC  = 5'd5,
      OP_SHL  = 5'd6,
      OP_SHR  = 5'd7,
      OP_AND  = 5'd8,
      OP_OR   = 5'd9,
      OP_XOR  = 5'd10,
      OP_INV  = 5'd11,
      OP_MIN  = 5'd12,
      OP_MAX  = 5'd13,
      OP_BCLR = 5'd14,
      OP_BSET = 5'd15,
      OP_LEAD = 5'd16
   } alu_op_e;

   // Control for the shared adder
   typedef struct packed {
      logic subtract;   // invert the subtrahend
      logic reverse;    // swap operand roles
      logic chain;      // use the stored carry as carry-in
   } addsub_ctl_t;

endpackage

// File: rtl/carry_alu_opsel.sv
module carry_alu_opsel #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input  logic              imm_sel_i,
   input  logic [DATA_W-1:0] reg_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [DATA_W-1:0] op2_o
);

   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_ext = {{PAD_W{1'b0}}, imm_i};
      end else begin : g_nopad
         assign imm_ext = imm_i[DATA_W-1:0];
      end
   endgenerate

   assign op2_o = imm_sel_i ? imm_ext : reg_i;

endmodule

// File: rtl/carry_alu_addsub.sv
module carry_alu_addsub
   import carry_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] rs1_i,
   input  logic [DATA_W-1:0] op2_i,
   input  addsub_ctl_t       ctl_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              carry_o
);

   localparam int EXT_W = DATA_W + 1;

   logic [DATA_W-1:0] lhs;
   logic [DATA_W-1:0] rhs;
   logic [DATA_W-1:0] rhs_eff;
   logic              cin;
   logic [EXT_W-1:0]  wide;

   always_comb begin
      lhs     = ctl_i.reverse ? op2_i : rs1_i;
      rhs     = ctl_i.reverse ? rs1_i : op2_i;
      rhs_eff = ctl_i.subtract ? ~rhs : rhs;
      // x - y - !c == x + ~y + c ; plain subtract has c = 1
      cin     = ctl_i.chain ? carry_i : ctl_i.subtract;
      wide    = {1'b0, lhs} + {1'b0, rhs_eff} + EXT_W'(cin);
   end

   // For subtraction the top bit is already the inverted borrow
   assign sum_o   = wide[DATA_W-1:0];
   assign carry_o = wide[DATA_W];

endmodule

// File: rtl/carry_alu_bitops.sv
module carry_alu_bitops
   import carry_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] rs1_i,
   input  logic [DATA_W-1:0] op2_i,
   output logic [DATA_W-1:0] res_o
);

   localparam int SH_W = $clog2(DATA_W);

   logic [SH_W-1:0]   amount;
   logic              to_left;
   logic [DATA_W-1:0] rev_in;
   logic [DATA_W-1:0] core_in;
   logic [DATA_W-1:0] stage [0:SH_W];
   logic [DATA_W-1:0] rev_out;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] bit_mask;

   assign amount  = op2_i[SH_W-1:0];
   assign to_left = (op_i == OP_SHL);

   // Left shift reuses the right shifter on bit-reversed data
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_rev
         assign rev_in[i]  = rs1_i[DATA_W-1-i];
         assign rev_out[i] = stage[SH_W][DATA_W-1-i];
      end
   endgenerate

   assign core_in  = to_left ? rev_in : rs1_i;
   assign stage[0] = core_in;

   generate
      for (genvar s = 0; s < SH_W; s++) begin : g_stage
         assign stage[s+1] = amount[s] ? (stage[s] >> (1 << s)) : stage[s];
      end
   endgenerate

   assign shifted  = to_left ? rev_out : stage[SH_W];
   assign bit_mask = DATA_W'(1) << amount;

   always_comb begin
      unique case (op_i)
         OP_SHL, OP_SHR: res_o = shifted;
         OP_AND:         res_o = rs1_i & op2_i;
         OP_OR:          res_o = rs1_i | op2_i;
         OP_XOR:         res_o = rs1_i ^ op2_i;
         OP_INV:         res_o = ~rs1_i;
         OP_MIN:         res_o = (rs1_i < op2_i) ? rs1_i : op2_i;
         OP_MAX:         res_o = (rs1_i > op2_i) ? rs1_i : op2_i;
         OP_BCLR:        res_o = rs1_i & ~bit_mask;
         OP_BSET:        res_o = rs1_i | bit_mask;
         default:        res_o = '0;
      endcase
   end

endmodule

// File: rtl/carry_alu_lead_scan.sv
module carry_alu_lead_scan #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(DATA_W) + 1
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic              ref_bit_i,
   output logic [IDX_W-1:0]  index_o
);

   logic [DATA_W-1:0] match;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_match
         assign match[i] = (word_i[i] == ref_bit_i);
      end
   endgenerate

   // Ascending walk: the highest matching index is written last
   always_comb begin
      index_o = IDX_W'(DATA_W);
      for (int i = 0; i < DATA_W; i++) begin
         if (match[i]) index_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/carry_alu.sv
module carry_alu
   import carry_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic              imm_sel_i,
   input  logic [DATA_W-1:0] rs1_i,
   input  logic [DATA_W-1:0] rs2_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o,
   output logic              carry_we_o
);

   localparam int IDX_W = $clog2(DATA_W) + 1;

   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("carry_alu: DATA_W must be a power of two of at least 2");
      end
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("carry_alu: IMM_W must lie in 1..DATA_W");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] op2;
   addsub_ctl_t       as_ctl;
   logic              is_arith;
   logic [DATA_W-1:0] as_sum;
   logic              as_carry;
   logic [DATA_W-1:0] bit_res;
   logic [IDX_W-1:0]  lead_idx;

   assign op = alu_op_e'(op_i);

   carry_alu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
      .imm_sel_i (imm_sel_i),
      .reg_i     (rs2_i),
      .imm_i     (imm_i),
      .op2_o     (op2)
   );

   always_comb begin
      as_ctl   = '0;
      is_arith = 1'b1;
      unique case (op)
         OP_ADD: as_ctl = '{subtract: 1'b0, reverse: 1'b0, chain: 1'b0};
         OP_ADC: as_ctl = '{subtract: 1'b0, reverse: 1'b0, chain: 1'b1};
         OP_SUB: as_ctl = '{subtract: 1'b1, reverse: 1'b0, chain: 1'b0};
         OP_SUC: as_ctl = '{subtract: 1'b1, reverse: 1'b0, chain: 1'b1};
         OP_RSB: as_ctl = '{subtract: 1'b1, reverse: 1'b1, chain: 1'b0};
         OP_RSC: as_ctl = '{subtract: 1'b1, reverse: 1'b1, chain: 1'b1};
         default: is_arith = 1'b0;
      endcase
   end

   carry_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .rs1_i   (rs1_i),
      .op2_i   (op2),
      .ctl_i   (as_ctl),
      .carry_i (carry_i),
      .sum_o   (as_sum),
      .carry_o (as_carry)
   );

   carry_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
      .op_i  (op),
      .rs1_i (rs1_i),
      .op2_i (op2),
      .res_o (bit_res)
   );

   carry_alu_lead_scan #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_lead (
      .word_i    (rs1_i),
      .ref_bit_i (op2[0]),
      .index_o   (lead_idx)
   );

   always_comb begin
      if (is_arith)            result_o = as_sum;
      else if (op == OP_LEAD)  result_o = DATA_W'(lead_idx);
      else                     result_o = bit_res;
   end

   assign carry_o    = is_arith ? as_carry : carry_i;
   assign carry_we_o = is_arith;

endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input logic [4:0]        op_i,
   input logic              imm_sel_i,
   input logic [DATA_W-1:0] rs1_i,
   input logic [DATA_W-1:0] rs2_i,
   input logic [IMM_W-1:0]  imm_i,
   input logic              carry_i,
   input logic [DATA_W-1:0] result_o,
   input logic              carry_o,
   input logic              carry_we_o
);

   logic [DATA_W-1:0] sec;
   logic [DATA_W:0]   full_add;

   always_comb begin
      sec      = imm_sel_i ? DATA_W'(imm_i) : rs2_i;
      full_add = {1'b0, rs1_i} + {1'b0, sec};

      // R2: plain add matches full-precision sum including carry bit
      if (op_i == 5'd0)
         a_r2_add_full: assert ({carry_o, result_o} == full_add)
            else $error("a_r2_add_full");

      // R10: write enable only for the six arithmetic forms
      a_r10_we_arith: assert (carry_we_o == (op_i <= 5'd5))
         else $error("a_r10_we_arith");

      // R10: carry preserved whenever it is not written
      if (!carry_we_o)
         a_r10_carry_hold: assert (carry_o == carry_i)
            else $error("a_r10_carry_hold");

      // R7: minimum never exceeds either operand
      if (op_i == 5'd12)
         a_r7_min_bound: assert (result_o <= rs1_i && result_o <= sec)
            else $error("a_r7_min_bound");

      // R9: search result within 0..DATA_W
      if (op_i == 5'd16)
         a_r9_lead_range: assert (result_o <= DATA_W)
            else $error("a_r9_lead_range");

      // R11: undefined codes yield zero
      if (op_i > 5'd16)
         a_r11_undef_zero: assert (result_o == '0)
            else $error("a_r11_undef_zero");
   end

endmodule

bind carry_alu carry_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
   .op_i       (op_i),
   .imm_sel_i  (imm_sel_i),
   .rs1_i      (rs1_i),
   .rs2_i      (rs2_i),
   .imm_i      (imm_i),
   .carry_i    (carry_i),
   .result_o   (result_o),
   .carry_o    (carry_o),
   .carry_we_o (carry_we_o)
);

// File: tb/carry_alu_test.sv
module carry_alu_test;

   typedef struct packed {
      logic [4:0]  op;
      logic        io;
      logic [31:0] rs1;
      logic [31:0] rs2;
      logic [7:0]  imm;
      logic        cin;
      logic [31:0] res;
      logic        cout;
      logic        we;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      // R2 add overflow, add with carry, immediate form (R1: rs2 ignored)
      '{5'd0,  1'b0, 32'hFFFFFFFF, 32'h00000001, 8'h00, 1'b0, 32'h00000000, 1'b1, 1'b1},
      '{5'd1,  1'b0, 32'hFFFFFFFF, 32'h00000000, 8'h00, 1'b1, 32'h00000000, 1'b1, 1'b1},
      '{5'd1,  1'b1, 32'h00000010, 32'hDEADBEEF, 8'h20, 1'b1, 32'h00000031, 1'b0, 1'b1},
      // R3 subtract borrow / exact equal / chained
      '{5'd2,  1'b0, 32'h00000005, 32'h00000007, 8'h00, 1'b1, 32'hFFFFFFFE, 1'b0, 1'b1},
      '{5'd2,  1'b0, 32'h00000007, 32'h00000007, 8'h00, 1'b0, 32'h00000000, 1'b1, 1'b1},
      '{5'd3,  1'b0, 32'h00000007, 32'h00000007, 8'h00, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b1},
      '{5'd3,  1'b0, 32'h0000000A, 32'h00000003, 8'h00, 1'b1, 32'h00000007, 1'b1, 1'b1},
      // R4 reverse forms
      '{5'd4,  1'b1, 32'h00000003, 32'h00000000, 8'h0A, 1'b0, 32'h00000007, 1'b1, 1'b1},
      '{5'd5,  1'b0, 32'h00000003, 32'h00000003, 8'h00, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b1},
      // R5 shifts with high amount bits
      '{5'd6,  1'b0, 32'h00000001, 32'h00000023, 8'h00, 1'b1, 32'h00000008, 1'b1, 1'b0},
      '{5'd7,  1'b1, 32'h80000000, 32'h00000000, 8'h1F, 1'b0, 32'h00000001, 1'b0, 1'b0},
      // R6 logic
      '{5'd8,  1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 8'h00, 1'b0, 32'hF000F000, 1'b0, 1'b0},
      '{5'd9,  1'b1, 32'h00000100, 32'h12345678, 8'hFF, 1'b1, 32'h000001FF, 1'b1, 1'b0},
      '{5'd10, 1'b0, 32'hFFFF0000, 32'h0F0F0F0F, 8'h00, 1'b0, 32'hF0F00F0F, 1'b0, 1'b0},
      '{5'd11, 1'b0, 32'h0000FFFF, 32'h12345678, 8'h00, 1'b1, 32'hFFFF0000, 1'b1, 1'b0},
      // R7 unsigned min / max
      '{5'd12, 1'b0, 32'h80000000, 32'h00000001, 8'h00, 1'b0, 32'h00000001, 1'b0, 1'b0},
      '{5'd13, 1'b0, 32'h80000000, 32'h00000001, 8'h00, 1'b0, 32'h80000000, 1'b0, 1'b0},
      // R8 clear / set with masked index
      '{5'd14, 1'b1, 32'hFFFFFFFF, 32'h00000000, 8'h3F, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b0},
      '{5'd15, 1'b0, 32'h00000000, 32'h00000020, 8'h00, 1'b0, 32'h00000001, 1'b0, 1'b0},
      // R9 leading-bit search
      '{5'd16, 1'b1, 32'h00010000, 32'h00000000, 8'h01, 1'b0, 32'h00000010, 1'b0, 1'b0},
      '{5'd16, 1'b1, 32'hFFFFFFFF, 32'h00000000, 8'h00, 1'b0, 32'h00000020, 1'b0, 1'b0},
      '{5'd16, 1'b1, 32'hFFFFFFFF, 32'h00000000, 8'h02, 1'b1, 32'h00000020, 1'b1, 1'b0},
      '{5'd16, 1'b0, 32'hFFFF0000, 32'h00000000, 8'h00, 1'b0, 32'h0000000F, 1'b0, 1'b0},
      // R11 undefined opcode
      '{5'd20, 1'b0, 32'h12345678, 32'h87654321, 8'h00, 1'b1, 32'h00000000, 1'b1, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  op;
   logic        io;
   logic [31:0] rs1;
   logic [31:0] rs2;
   logic [7:0]  imm;
   logic        cin;
   logic [31:0] res;
   logic        cout;
   logic        we;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   carry_alu uut (
      .op_i       (op),
      .imm_sel_i  (io),
      .rs1_i      (rs1),
      .rs2_i      (rs2),
      .imm_i      (imm),
      .carry_i    (cin),
      .result_o   (res),
      .carry_o    (cout),
      .carry_we_o (we)
   );

   function automatic string req_of(input logic [4:0] code);
      case (code)
         5'd0, 5'd1:   return "R2";
         5'd2, 5'd3:   return "R3";
         5'd4, 5'd5:   return "R4";
         5'd6, 5'd7:   return "R5";
         5'd8, 5'd9, 5'd10, 5'd11: return "R6";
         5'd12, 5'd13: return "R7";
         5'd14, 5'd15: return "R8";
         5'd16:        return "R9";
         default:      return "R11";
      endcase
   endfunction

   task automatic apply(input vec_t v);
      @(posedge clk);
      op = v.op; io = v.io; rs1 = v.rs1; rs2 = v.rs2; imm = v.imm; cin = v.cin;
      @(negedge clk);
   endtask

   task automatic compare(input string tag, input logic [31:0] er,
                          input logic ec, input logic ew);
      checks++;
      if (res !== er || cout !== ec || we !== ew) begin
         errors++;
         $display("FAIL %s: op=%0d got res=%h c=%b we=%b expected res=%h c=%b we=%b",
                  tag, op, res, cout, we, er, ec, ew);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      vec_t v;
      op = '0; io = 1'b0; rs1 = '0; rs2 = '0; imm = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // Idle inputs: opcode 0 adds zeros (R2)
      compare("R2 idle", 32'h0, 1'b0, 1'b1);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         compare(req_of(VECS[i].op), VECS[i].res, VECS[i].cout, VECS[i].we);
      end

      // R1: immediate selected, rs2 changed -> result unchanged
      v = '{5'd8, 1'b1, 32'hFFFFFFFF, 32'h00000000, 8'hA5, 1'b0, 32'h000000A5, 1'b0, 1'b0};
      apply(v); compare("R1 imm", v.res, v.cout, v.we);
      v.rs2 = 32'hFFFFFFFF;
      apply(v); compare("R1 rs2 ignored", v.res, v.cout, v.we);
      v.io = 1'b0;
      v.res = 32'hFFFFFFFF;
      apply(v); compare("R1 reg", v.res, v.cout, v.we);

      // R6: inversion ignores second operand
      v = '{5'd11, 1'b0, 32'h12340000, 32'hFFFFFFFF, 8'hFF, 1'b0, 32'hEDCBFFFF, 1'b0, 1'b0};
      apply(v); compare("R6 inv ignores op2", v.res, v.cout, v.we);

      // R10: carry passes through for each non-arithmetic opcode, both values
      for (int c = 6; c <= 16; c++) begin
         for (int k = 0; k < 2; k++) begin
            @(posedge clk);
            op = 5'(c); io = 1'b0; rs1 = 32'h0; rs2 = 32'h0; cin = k[0];
            @(negedge clk);
            checks++;
            if (cout !== k[0] || we !== 1'b0) begin
               errors++;
               $display("FAIL R10: op=%0d got c=%b we=%b expected c=%b we=0",
                        c, cout, we, k[0]);
            end
         end
      end

      // R10: write enable for each arithmetic opcode
      for (int c = 0; c <= 5; c++) begin
         @(posedge clk);
         op = 5'(c); cin = 1'b0;
         @(negedge clk);
         checks++;
         if (we !== 1'b1) begin
            errors++;
            $display("FAIL R10: op=%0d got we=%b expected we=1", c, we);
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule